// File: doc/BRIEF.md
# Planar Frame Buffer Read Path

This block sits between a four-plane frame buffer and the host side of a graphics memory interface. Each time the memory delivers a 32-bit word (one byte per plane), the block captures the whole word into a display latch and reduces the word to the single byte the host receives. The latch is exported so that a separate write path can combine it with host data. Address generation, memory timing and the host bus protocol are handled elsewhere.

The reduction has two modes. In pick mode, one plane's byte is returned. The plane comes from a programmed plane index, unless an addressing flag hands that choice to the low read-address bits. In match mode, each of the eight pixel positions is tested against a 4-bit reference color, and the block returns one bit per pixel. This turns 4-bpp planar pixels into a 1-bpp mask, and a per-plane enable leaves chosen planes out of the test.

Data flows through a valid-only stream. The memory side offers `fb_vld` with no ready, because the block accepts a word in every cycle. The host side has `rd_vld` and no ready, so the consumer has to take each byte in the cycle it is flagged. No back-pressure exists on either side. A new word may arrive in every cycle.

Top module: `planar_rd_path`

## Requirements
- R1: While `rst_n` is low and after its release, `rd_vld` is 0, `rd_byte` is 0x00 and `latch_q` is 0. The configuration resets to pick mode, plane index 0, both addressing flags clear, reference color 0 and compare enables 0.
- R2: On every clock edge with `fb_vld` high, `latch_q` takes all 32 bits of `fb_data`. In cycles without `fb_vld`, `latch_q` holds its value.
- R3: `rd_vld` is high in exactly the cycle after each cycle that has `fb_vld` high. `rd_byte` is updated at that same edge and holds its value in every other cycle.
- R4: In pick mode (`cfg_mode`=0) with both addressing flags clear, `rd_byte` equals byte s of `fb_data`, that is bits [8s+7:8s], where s is `cfg_plane`.
- R5: When `cfg_chain` is 1 in pick mode, s equals `fb_addr[1:0]`, whatever `cfg_plane` holds. This holds even when `cfg_pair` is also 1.
- R6: When `cfg_pair` is 1 and `cfg_chain` is 0 in pick mode, s equals {`cfg_plane[1]`, `fb_addr[0]`}.
- R7: In match mode (`cfg_mode`=1), bit n of `rd_byte` is 1 exactly when `fb_data[8b+n]` equals `cfg_color[b]` for every plane b whose `cfg_care[b]` is 1.
- R8: A plane whose `cfg_care` bit is 0 always counts as matching. With `cfg_care` = 0 in match mode, `rd_byte` is 0xFF for any data.
- R9: Configuration is captured on an edge with `cfg_we` high. A read strobed at that same edge uses the previous configuration, and later reads use the new one. A configuration write alone changes neither `rd_byte` nor `latch_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_mode | input | 1 | 0 pick mode, 1 match mode |
| cfg_plane | input | 2 | Programmed plane index |
| cfg_chain | input | 1 | Plane index taken from the address bits |
| cfg_pair | input | 1 | Address bit 0 replaces the low bit of the plane index |
| cfg_color | input | 4 | Reference color, one bit per plane |
| cfg_care | input | 4 | Per-plane compare enable |
| fb_vld | input | 1 | Frame buffer read word valid |
| fb_data | input | 32 | Frame buffer word, plane b in bits [8b+7:8b] |
| fb_addr | input | 2 | Low read-address bits for the word |
| rd_vld | output | 1 | Host byte valid, one cycle after `fb_vld` |
| rd_byte | output | 8 | Byte returned to the host |
| latch_q | output | 32 | Display latch for the write path |

## Verification
Pick mode is swept over every combination of plane index, address bits and the two addressing flags, using data words whose four bytes all differ. Any wrong plane choice, or the wrong flag winning, therefore gives a visibly different byte. Match mode is swept over all 256 pairs of reference color and compare enable, using all-zero, all-one and mixed words. This separates a plane that is inverted, mis-indexed or wrongly excluded. The all-excluded case is included in the sweep. Idle cycles after each read, and a configuration write that lands on the same edge as a strobe, show the hold and ordering rules.

// File: rtl/planar_rd_pkg.sv
package planar_rd_pkg;

  typedef enum logic {
    RD_PICK  = 1'b0,
    RD_MATCH = 1'b1
  } rd_mode_e;

endpackage

// File: rtl/planar_cfg_regs.sv
module planar_cfg_regs
  import planar_rd_pkg::*;
#(
  parameter int NPLANES = 4,
  localparam int SELW = $clog2(NPLANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               mode_in,
  input  logic [SELW-1:0]    plane_in,
  input  logic               chain_in,
  input  logic               pair_in,
  input  logic [NPLANES-1:0] color_in,
  input  logic [NPLANES-1:0] care_in,
  output rd_mode_e           mode_q,
  output logic [SELW-1:0]    plane_q,
  output logic               chain_q,
  output logic               pair_q,
  output logic [NPLANES-1:0] color_q,
  output logic [NPLANES-1:0] care_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= RD_PICK;
      plane_q <= '0;
      chain_q <= 1'b0;
      pair_q  <= 1'b0;
      color_q <= '0;
      care_q  <= '0;
    end else if (we) begin
      mode_q  <= rd_mode_e'(mode_in);
      plane_q <= plane_in;
      chain_q <= chain_in;
      pair_q  <= pair_in;
      color_q <= color_in;
      care_q  <= care_in;
    end
  end

endmodule

// File: rtl/planar_plane_sel.sv
module planar_plane_sel #(
  parameter int NPLANES = 4,
  localparam int SELW = $clog2(NPLANES)
) (
  input  logic [SELW-1:0] plane,
  input  logic            chain,
  input  logic            pair,
  input  logic [SELW-1:0] addr,
  output logic [SELW-1:0] sel
);

  always_comb begin
    if (chain)
      sel = addr;
    else if (pair)
      sel = {plane[SELW-1:1], addr[0]};
    else
      sel = plane;
  end

  // R5: address bits decide the plane whenever chain addressing is on
  always_comb begin
    if (chain) p_chain_wins_r5: assert (sel == addr);
  end

endmodule

// File: rtl/planar_color_match.sv
module planar_color_match #(
  parameter int NPLANES = 4,
  parameter int PLANE_W = 8,
  localparam int WORD_W = NPLANES * PLANE_W
) (
  input  logic [WORD_W-1:0]  word,
  input  logic [NPLANES-1:0] color,
  input  logic [NPLANES-1:0] care,
  output logic [PLANE_W-1:0] hits
);

  for (genvar n = 0; n < PLANE_W; n++) begin : g_pix
    logic [NPLANES-1:0] ok;
    for (genvar b = 0; b < NPLANES; b++) begin : g_pln
      assign ok[b] = !care[b] || (word[b*PLANE_W+n] == color[b]);
    end
    assign hits[n] = &ok;
  end

endmodule

// File: rtl/planar_rd_path.sv
module planar_rd_path
  import planar_rd_pkg::*;
#(
  parameter int NPLANES = 4,
  parameter int PLANE_W = 8,
  localparam int SELW = $clog2(NPLANES),
  localparam int WORD_W = NPLANES * PLANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_mode,
  input  logic [SELW-1:0]    cfg_plane,
  input  logic               cfg_chain,
  input  logic               cfg_pair,
  input  logic [NPLANES-1:0] cfg_color,
  input  logic [NPLANES-1:0] cfg_care,
  input  logic               fb_vld,
  input  logic [WORD_W-1:0]  fb_data,
  input  logic [SELW-1:0]    fb_addr,
  output logic               rd_vld,
  output logic [PLANE_W-1:0] rd_byte,
  output logic [WORD_W-1:0]  latch_q
);

  rd_mode_e           mode_q;
  logic [SELW-1:0]    plane_q;
  logic               chain_q;
  logic               pair_q;
  logic [NPLANES-1:0] color_q;
  logic [NPLANES-1:0] care_q;

  planar_cfg_regs #(.NPLANES(NPLANES)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .mode_in  (cfg_mode),
    .plane_in (cfg_plane),
    .chain_in (cfg_chain),
    .pair_in  (cfg_pair),
    .color_in (cfg_color),
    .care_in  (cfg_care),
    .mode_q   (mode_q),
    .plane_q  (plane_q),
    .chain_q  (chain_q),
    .pair_q   (pair_q),
    .color_q  (color_q),
    .care_q   (care_q)
  );

  logic [SELW-1:0] sel;

  planar_plane_sel #(.NPLANES(NPLANES)) u_sel (
    .plane (plane_q),
    .chain (chain_q),
    .pair  (pair_q),
    .addr  (fb_addr),
    .sel   (sel)
  );

  logic [PLANE_W-1:0] planes [NPLANES];
  for (genvar b = 0; b < NPLANES; b++) begin : g_split
    assign planes[b] = fb_data[b*PLANE_W +: PLANE_W];
  end

  logic [PLANE_W-1:0] match_bits;

  planar_color_match #(.NPLANES(NPLANES), .PLANE_W(PLANE_W)) u_match (
    .word  (fb_data),
    .color (color_q),
    .care  (care_q),
    .hits  (match_bits)
  );

  logic [PLANE_W-1:0] next_byte;
  assign next_byte = (mode_q == RD_MATCH) ? match_bits : planes[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_byte <= '0;
      latch_q <= '0;
    end else begin
      rd_vld <= fb_vld;
      if (fb_vld) begin
        latch_q <= fb_data;
        rd_byte <= next_byte;
      end
    end
  end

  // R2: the latch takes the whole word on a read
  p_latch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_vld |=> latch_q == $past(fb_data));

  // R2: the latch holds between reads
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_vld |=> $stable(latch_q));

  // R3: the host byte holds when no word arrived
  p_byte_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_vld |=> $stable(rd_byte) && !rd_vld);

  // R8: with every plane excluded, match mode returns all ones
  p_all_excluded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_vld && mode_q == RD_MATCH && care_q == '0 && !cfg_we |=> rd_byte == '1);

endmodule

// File: tb/planar_rd_path_tb.sv
module planar_rd_path_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [1:0]  cfg_plane = '0;
  logic        cfg_chain = 1'b0;
  logic        cfg_pair = 1'b0;
  logic [3:0]  cfg_color = '0;
  logic [3:0]  cfg_care = '0;
  logic        fb_vld = 1'b0;
  logic [31:0] fb_data = '0;
  logic [1:0]  fb_addr = '0;
  logic        rd_vld;
  logic [7:0]  rd_byte;
  logic [31:0] latch_q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  planar_rd_path u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_plane(cfg_plane), .cfg_chain(cfg_chain), .cfg_pair(cfg_pair),
    .cfg_color(cfg_color), .cfg_care(cfg_care), .fb_vld(fb_vld),
    .fb_data(fb_data), .fb_addr(fb_addr), .rd_vld(rd_vld),
    .rd_byte(rd_byte), .latch_q(latch_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pick(input logic [31:0] d, input logic [1:0] pl,
                                          input logic [1:0] a, input logic ch, input logic pr);
    int s;
    if (ch) s = int'(a);
    else if (pr) s = 2 * int'(pl[1]) + int'(a[0]);
    else s = int'(pl);
    return d[8*s +: 8];
  endfunction

  function automatic logic [7:0] exp_match(input logic [31:0] d, input logic [3:0] col,
                                           input logic [3:0] care);
    logic [7:0] r = 8'hFF;
    for (int n = 0; n < 8; n++)
      for (int b = 0; b < 4; b++)
        if (care[b] && (d[8*b+n] != col[b])) r[n] = 1'b0;
    return r;
  endfunction

  task automatic set_cfg(input logic m, input logic [1:0] pl, input logic ch,
                         input logic pr, input logic [3:0] col, input logic [3:0] care);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = m; cfg_plane = pl; cfg_chain = ch;
    cfg_pair = pr; cfg_color = col; cfg_care = care;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one strobe, check the result, then one idle cycle to check hold
  task automatic do_read(input string req, input logic [31:0] d, input logic [1:0] a,
                         input logic [7:0] exp);
    fb_vld = 1'b1; fb_data = d; fb_addr = a;
    @(negedge clk);
    fb_vld = 1'b0; fb_data = ~d;
    chk("R3 valid", {31'd0, rd_vld}, 32'd1);
    chk(req, {24'd0, rd_byte}, {24'd0, exp});
    chk("R2 latch", latch_q, d);
    @(negedge clk);
    chk("R3 idle", {31'd0, rd_vld}, 32'd0);
    chk("R3 hold", {24'd0, rd_byte}, {24'd0, exp});
    chk("R2 hold", latch_q, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 vld", {31'd0, rd_vld}, 32'd0);
    chk("R1 byte", {24'd0, rd_byte}, 32'd0);
    chk("R1 latch", latch_q, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after", {31'd0, rd_vld}, 32'd0);
    // R1: reset config is match mode off, plane 0
    do_read("R1 default plane", 32'hA1B2C3D4, 2'd3, 8'hD4);

    // R4 R5 R6: pick mode sweep over flags, plane index, address
    for (int ch = 0; ch < 2; ch++)
      for (int pr = 0; pr < 2; pr++)
        for (int pl = 0; pl < 4; pl++) begin
          set_cfg(1'b0, 2'(pl), 1'(ch), 1'(pr), 4'h0, 4'h0);
          for (int a = 0; a < 4; a++)
            for (int k = 0; k < 2; k++) begin
              logic [31:0] d = 32'h0F1E2D3C + 32'(k) * 32'h11223344;
              string r = (ch == 1) ? "R5 chain" : (pr == 1) ? "R6 pair" : "R4 pick";
              do_read(r, d, 2'(a), exp_pick(d, 2'(pl), 2'(a), 1'(ch), 1'(pr)));
            end
        end

    // R7 R8: match mode sweep of color and care
    for (int col = 0; col < 16; col++)
      for (int care = 0; care < 16; care++) begin
        set_cfg(1'b1, 2'd0, 1'b0, 1'b0, 4'(col), 4'(care));
        for (int k = 0; k < 3; k++) begin
          logic [31:0] d = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFFFFFF
                          : 32'h5AC3_96E1 ^ (32'(col) * 32'h01010101);
          do_read((care == 0) ? "R8 excluded" : "R7 match", d, 2'(k),
                  exp_match(d, 4'(col), 4'(care)));
        end
      end

    // R9: config write on the same edge as a read uses old config
    set_cfg(1'b0, 2'd1, 1'b0, 1'b0, 4'h0, 4'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_plane = 2'd2;
    fb_vld = 1'b1; fb_data = 32'h44332211; fb_addr = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; fb_vld = 1'b0;
    chk("R9 old cfg", {24'd0, rd_byte}, 32'h22);
    // R9: config write alone leaves outputs alone
    cfg_we = 1'b1; cfg_plane = 2'd3;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R9 no effect byte", {24'd0, rd_byte}, 32'h22);
    chk("R9 no effect latch", latch_q, 32'h44332211);
    do_read("R9 new cfg", 32'h44332211, 2'd0, 8'h44);

    // R3: back-to-back strobes give back-to-back valids
    fb_vld = 1'b1; fb_data = 32'h01020304;
    @(negedge clk);
    chk("R3 b2b byte1", {24'd0, rd_byte}, 32'h01);
    fb_data = 32'hF0E0D0C0;
    @(negedge clk);
    fb_vld = 1'b0;
    chk("R3 b2b vld", {31'd0, rd_vld}, 32'd1);
    chk("R3 b2b byte2", {24'd0, rd_byte}, 32'hF0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule